// File: doc/BRIEF.md
# Current-Limit Fault Response Controller

This block sits between two overcurrent comparators and the gate-drive enable of a motor power stage. One comparator reports, once per PWM period, whether phase current is above the cycle-by-cycle limit. The other reports whether current is above the higher lock limit. The block qualifies each comparator by ignoring it for a blanking window after every output switching event and by requiring it to stay high for a deglitch window. The qualified events are then turned into a gate-enable decision, sticky report flags and a latched-fault indication.

Two 4-bit mode fields select the response. Each field contains don't-care bits. The cycle-by-cycle field selects one of: recover at the next PWM period, recover once a recovery-threshold comparator reports low current, recover after a set number of PWM periods, report only, or ignore. The lock field selects one of: latched shutdown until a fault clear, timed automatic retry, report only, or ignore. All durations are parameters counted in system clock cycles. No pin carries a data stream, so every interface is a plain level or strobe signal with no handshake.

Top module: `ilim_fault_ctrl`

## Requirements
- R1: After a clock cycle in which `sw_edge` is sampled high, both comparator inputs are ignored on that edge and on the next BLANK_CYC edges. A comparator that is held high from before the switching event is first counted on edge BLANK_CYC+1 after the event.
- R2: A comparator counts as a trip only after it has been sampled high on DGL_CYC consecutive unblanked edges. When a trip causes a shutdown, `gate_en` falls on the following edge. A high pulse shorter than DGL_CYC edges has no effect.
- R3: Cycle-by-cycle modes 0000 and 0001 (next-period recovery): a trip drives `gate_en` low. The shutdown ends on the first edge that samples `cyc_start` high while no trip is present.
- R4: Cycle-by-cycle modes 0010 and 0011 (threshold recovery): the shutdown ignores `cyc_start`. It ends on the first edge that samples `cbc_below` high while no trip is present.
- R5: Cycle-by-cycle modes 0100 and 0101 (counted recovery): the shutdown ends on the edge that samples the N_CYC-th `cyc_start` pulse after the last trip.
- R6: Cycle-by-cycle mode 0110 (report only): a trip sets `cbc_flag` and leaves `gate_en` high. In modes 0000 to 0101, a trip also sets `cbc_flag`, and the flag stays set until cleared.
- R7: Cycle-by-cycle mode 0111 and modes 1000 to 1111 ignore `cbc_raw`: `gate_en` stays high and `cbc_flag` stays low.
- R8: Lock modes 0000 to 0011 (latched): a trip sets `lock_latched` and `lock_flag` and drives `gate_en` low. All three hold, even after the comparator falls, until `flt_clr`.
- R9: Lock modes 0100 to 0111 (retry): a trip drives `gate_en` low, restarting the timer on every trip. `gate_en` returns high RETRY_CYC edges after the last trip. `lock_latched` stays low.
- R10: Lock mode 1000 sets `lock_flag` on a trip without shutting down. Every other lock mode from 1001 to 1111 ignores `lock_raw`.
- R11: The edge that samples `flt_clr` high clears `cbc_flag`, `lock_flag` and `lock_latched`. The clear wins over a trip on the same edge.
- R12: After reset `gate_en` is high and all flags and the latch are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_edge | input | 1 | Strobe: a gate output has just switched; starts blanking |
| cyc_start | input | 1 | Strobe: start of a PWM period |
| cbc_raw | input | 1 | Cycle-by-cycle limit comparator, high = over limit |
| cbc_below | input | 1 | High = current below the recovery threshold |
| lock_raw | input | 1 | Lock-limit comparator, high = over limit |
| cbc_mode | input | 4 | Cycle-by-cycle response select |
| lock_mode | input | 4 | Lock response select |
| flt_clr | input | 1 | Clears flags and latched fault |
| gate_en | output | 1 | High = power stage may be driven |
| cbc_flag | output | 1 | Sticky cycle-by-cycle event report |
| lock_flag | output | 1 | Sticky lock event report |
| lock_latched | output | 1 | Latched lock shutdown active |

## Verification
The assertions assume that the strobes and comparators are synchronous to `clk`. They also assume the mode fields only change while no shutdown timer is depending on them. The stimulus drives every input one time unit after a rising edge, and changes modes only between scenarios, after a fault clear and a settle period in an ignoring mode. Comparators are lowered right after each shutdown. This lets each recovery condition be seen on its own rather than being masked by a fresh trip.

// File: rtl/ilim_pkg.sv
package ilim_pkg;

  typedef enum logic [2:0] {
    CBC_NEXT,
    CBC_THRESH,
    CBC_NCYC,
    CBC_REPORT,
    CBC_IGNORE
  } cbc_pol_e;

  typedef enum logic [1:0] {
    LK_LATCH,
    LK_RETRY,
    LK_REPORT,
    LK_IGNORE
  } lock_pol_e;

  function automatic cbc_pol_e decode_cbc(input logic [3:0] m);
    cbc_pol_e p;
    casez (m)
      4'b000?: p = CBC_NEXT;
      4'b001?: p = CBC_THRESH;
      4'b010?: p = CBC_NCYC;
      4'b0110: p = CBC_REPORT;
      default: p = CBC_IGNORE;
    endcase
    return p;
  endfunction

  function automatic lock_pol_e decode_lock(input logic [3:0] m);
    lock_pol_e p;
    casez (m)
      4'b00??: p = LK_LATCH;
      4'b01??: p = LK_RETRY;
      4'b1000: p = LK_REPORT;
      default: p = LK_IGNORE;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/ilim_qual.sv
module ilim_qual #(
  parameter int BLANK_CYC = 250,
  parameter int DGL_CYC   = 750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_edge,
  input  logic raw,
  output logic qual
);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam int DW = $clog2(DGL_CYC + 1);

  logic [BW-1:0] blank_cnt;
  logic [DW-1:0] dgl_cnt;
  logic          blanking;

  assign blanking = sw_edge || (blank_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_cnt <= '0;
    end else if (sw_edge) begin
      blank_cnt <= BW'(BLANK_CYC);
    end else if (blank_cnt != '0) begin
      blank_cnt <= blank_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dgl_cnt <= '0;
    end else if (blanking || !raw) begin
      dgl_cnt <= '0;
    end else if (dgl_cnt != DW'(DGL_CYC)) begin
      dgl_cnt <= dgl_cnt + 1'b1;
    end
  end

  assign qual = (dgl_cnt == DW'(DGL_CYC));

  // R1
  blank_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blanking |=> !qual);

  // R2
  raw_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qual |-> $past(raw));

endmodule

// File: rtl/ilim_cbc_policy.sv
module ilim_cbc_policy
  import ilim_pkg::*;
#(
  parameter int N_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mode,
  input  logic       qual,
  input  logic       cyc_start,
  input  logic       below_thr,
  input  logic       flt_clr,
  output logic       shut,
  output logic       flag
);
  localparam int NW = $clog2(N_CYC + 1);

  cbc_pol_e      pol;
  logic          drives;
  logic          reports;
  logic          trip;
  logic [NW-1:0] cyc_cnt;

  assign pol     = decode_cbc(mode);
  assign drives  = (pol == CBC_NEXT) || (pol == CBC_THRESH) || (pol == CBC_NCYC);
  assign reports = drives || (pol == CBC_REPORT);
  assign trip    = qual && drives;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shut    <= 1'b0;
      cyc_cnt <= '0;
    end else if (!drives) begin
      shut    <= 1'b0;
      cyc_cnt <= '0;
    end else if (trip) begin
      shut    <= 1'b1;
      cyc_cnt <= '0;
    end else if (shut) begin
      unique case (pol)
        CBC_NEXT:   if (cyc_start) shut <= 1'b0;
        CBC_THRESH: if (below_thr) shut <= 1'b0;
        CBC_NCYC: begin
          if (cyc_start) begin
            if (cyc_cnt == NW'(N_CYC - 1)) begin
              shut    <= 1'b0;
              cyc_cnt <= '0;
            end else begin
              cyc_cnt <= cyc_cnt + 1'b1;
            end
          end
        end
        default: shut <= 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (flt_clr) begin
      flag <= 1'b0;
    end else if (qual && reports) begin
      flag <= 1'b1;
    end
  end

  // R3
  next_cycle_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shut && cyc_start && !qual && pol == CBC_NEXT) |=> !shut);

  // R5
  ncyc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_cnt < NW'(N_CYC));

endmodule

// File: rtl/ilim_lock_policy.sv
module ilim_lock_policy
  import ilim_pkg::*;
#(
  parameter int RETRY_CYC = 25000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mode,
  input  logic       qual,
  input  logic       flt_clr,
  output logic       shut,
  output logic       latched,
  output logic       flag
);
  localparam int RW = $clog2(RETRY_CYC + 1);

  lock_pol_e     pol;
  logic          reports;
  logic          retry_off;
  logic [RW-1:0] retry_cnt;

  assign pol     = decode_lock(mode);
  assign reports = (pol == LK_LATCH) || (pol == LK_RETRY) || (pol == LK_REPORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched <= 1'b0;
    end else if (flt_clr) begin
      latched <= 1'b0;
    end else if (qual && pol == LK_LATCH) begin
      latched <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retry_off <= 1'b0;
      retry_cnt <= '0;
    end else if (pol != LK_RETRY) begin
      retry_off <= 1'b0;
      retry_cnt <= '0;
    end else if (qual) begin
      retry_off <= 1'b1;
      retry_cnt <= '0;
    end else if (retry_off) begin
      if (retry_cnt == RW'(RETRY_CYC - 1)) begin
        retry_off <= 1'b0;
        retry_cnt <= '0;
      end else begin
        retry_cnt <= retry_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (flt_clr) begin
      flag <= 1'b0;
    end else if (qual && reports) begin
      flag <= 1'b1;
    end
  end

  assign shut = latched || retry_off;

  // R8
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && !flt_clr) |=> latched);

  // R9
  retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_cnt < RW'(RETRY_CYC));

endmodule

// File: rtl/ilim_fault_ctrl.sv
module ilim_fault_ctrl #(
  parameter int BLANK_CYC = 250,
  parameter int DGL_CYC   = 750,
  parameter int N_CYC     = 4,
  parameter int RETRY_CYC = 25000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_edge,
  input  logic       cyc_start,
  input  logic       cbc_raw,
  input  logic       cbc_below,
  input  logic       lock_raw,
  input  logic [3:0] cbc_mode,
  input  logic [3:0] lock_mode,
  input  logic       flt_clr,
  output logic       gate_en,
  output logic       cbc_flag,
  output logic       lock_flag,
  output logic       lock_latched
);
  localparam int NSRC = 2;

  logic [NSRC-1:0] raw_vec;
  logic [NSRC-1:0] qual_vec;
  logic            cbc_shut;
  logic            lock_shut;

  assign raw_vec = {lock_raw, cbc_raw};

  for (genvar g = 0; g < NSRC; g++) begin : g_qual
    ilim_qual #(
      .BLANK_CYC(BLANK_CYC),
      .DGL_CYC  (DGL_CYC)
    ) i_qual (
      .clk    (clk),
      .rst_n  (rst_n),
      .sw_edge(sw_edge),
      .raw    (raw_vec[g]),
      .qual   (qual_vec[g])
    );
  end

  ilim_cbc_policy #(.N_CYC(N_CYC)) i_cbc (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (cbc_mode),
    .qual     (qual_vec[0]),
    .cyc_start(cyc_start),
    .below_thr(cbc_below),
    .flt_clr  (flt_clr),
    .shut     (cbc_shut),
    .flag     (cbc_flag)
  );

  ilim_lock_policy #(.RETRY_CYC(RETRY_CYC)) i_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (lock_mode),
    .qual   (qual_vec[1]),
    .flt_clr(flt_clr),
    .shut   (lock_shut),
    .latched(lock_latched),
    .flag   (lock_flag)
  );

  assign gate_en = !(cbc_shut || lock_shut);

  // R11
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_clr |=> (!cbc_flag && !lock_flag && !lock_latched));

endmodule

// File: tb/test_ilim_fault_ctrl.sv
`timescale 1ns/1ps
module test_ilim_fault_ctrl;
  localparam int BLK = 4;
  localparam int DGL = 3;
  localparam int NCY = 3;
  localparam int RTY = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_edge = 0, cyc_start = 0, cbc_raw = 0, cbc_below = 0, lock_raw = 0, flt_clr = 0;
  logic [3:0] cbc_mode = 4'b1000, lock_mode = 4'b1001;
  logic gate_en, cbc_flag, lock_flag, lock_latched;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  ilim_fault_ctrl #(.BLANK_CYC(BLK), .DGL_CYC(DGL), .N_CYC(NCY), .RETRY_CYC(RTY)) i_ilim_fault_ctrl (
    .clk(clk), .rst_n(rst_n), .sw_edge(sw_edge), .cyc_start(cyc_start),
    .cbc_raw(cbc_raw), .cbc_below(cbc_below), .lock_raw(lock_raw),
    .cbc_mode(cbc_mode), .lock_mode(lock_mode), .flt_clr(flt_clr),
    .gate_en(gate_en), .cbc_flag(cbc_flag), .lock_flag(lock_flag), .lock_latched(lock_latched));

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic settle();
    cbc_raw = 0; lock_raw = 0; cbc_below = 0; cyc_start = 0; sw_edge = 0;
    cbc_mode = 4'b1000; lock_mode = 4'b1001;
    flt_clr = 1; tick(); flt_clr = 0; tick(5);
  endtask

  task automatic t_reset();
    chk("R12 gate_en", gate_en, 1'b1);
    chk("R12 cbc_flag", cbc_flag, 1'b0);
    chk("R12 lock_flag", lock_flag, 1'b0);
    chk("R12 lock_latched", lock_latched, 1'b0);
  endtask

  task automatic t_deglitch();
    cbc_mode = 4'b0000;
    cbc_raw = 1; tick(DGL - 1); cbc_raw = 0; tick(4);
    chk("R2 short pulse gate", gate_en, 1'b1);
    chk("R2 short pulse flag", cbc_flag, 1'b0);
    cbc_raw = 1; tick(DGL);
    chk("R2 before trip edge", gate_en, 1'b1);
    tick();
    chk("R2 trip edge", gate_en, 1'b0);
    settle();
  endtask

  task automatic t_blank();
    cbc_mode = 4'b0000;
    cbc_raw = 1; sw_edge = 1; tick(); sw_edge = 0;
    tick(BLK + DGL);
    chk("R1 blanked window", gate_en, 1'b1);
    tick();
    chk("R1 after blanking", gate_en, 1'b0);
    settle();
  endtask

  task automatic t_next();
    cbc_mode = 4'b0001;
    cbc_raw = 1; tick(DGL + 1); cbc_raw = 0;
    chk("R3 shut", gate_en, 1'b0);
    tick(2);
    chk("R3 no cycle yet", gate_en, 1'b0);
    cyc_start = 1; tick(); cyc_start = 0;
    chk("R3 recovered", gate_en, 1'b1);
    chk("R6 flag set", cbc_flag, 1'b1);
    settle();
  endtask

  task automatic t_thresh();
    cbc_mode = 4'b0011;
    cbc_raw = 1; tick(DGL + 1); cbc_raw = 0; tick(2);
    cyc_start = 1; tick(); cyc_start = 0;
    chk("R4 cycle ignored", gate_en, 1'b0);
    cbc_below = 1; tick(); cbc_below = 0;
    chk("R4 recovered", gate_en, 1'b1);
    settle();
  endtask

  task automatic t_ncyc();
    cbc_mode = 4'b0100;
    cbc_raw = 1; tick(DGL + 1); cbc_raw = 0; tick(2);
    for (int k = 1; k < NCY; k++) begin
      cyc_start = 1; tick(); cyc_start = 0; tick();
      chk("R5 still shut", gate_en, 1'b0);
    end
    cyc_start = 1; tick(); cyc_start = 0;
    chk("R5 recovered", gate_en, 1'b1);
    settle();
  endtask

  task automatic t_report_cbc();
    cbc_mode = 4'b0110;
    cbc_raw = 1; tick(DGL + 3); cbc_raw = 0;
    chk("R6 gate kept", gate_en, 1'b1);
    chk("R6 flag", cbc_flag, 1'b1);
    tick(3);
    chk("R6 flag sticky", cbc_flag, 1'b1);
    settle();
  endtask

  task automatic t_ignore_cbc(input logic [3:0] m);
    cbc_mode = m;
    cbc_raw = 1; tick(DGL + 3); cbc_raw = 0;
    chk("R7 gate", gate_en, 1'b1);
    chk("R7 flag", cbc_flag, 1'b0);
    settle();
  endtask

  task automatic t_latch();
    lock_mode = 4'b0010;
    lock_raw = 1; tick(DGL + 1); lock_raw = 0;
    chk("R8 gate", gate_en, 1'b0);
    tick(20);
    chk("R8 gate held", gate_en, 1'b0);
    chk("R8 latched", lock_latched, 1'b1);
    chk("R8 flag", lock_flag, 1'b1);
    flt_clr = 1; tick(); flt_clr = 0;
    chk("R11 gate after clear", gate_en, 1'b1);
    chk("R11 latched cleared", lock_latched, 1'b0);
    chk("R11 flag cleared", lock_flag, 1'b0);
    settle();
  endtask

  task automatic t_retry();
    lock_mode = 4'b0101;
    lock_raw = 1; tick(DGL + 1); lock_raw = 0;
    chk("R9 shut", gate_en, 1'b0);
    tick(RTY);
    chk("R9 before timeout", gate_en, 1'b0);
    chk("R9 not latched", lock_latched, 1'b0);
    tick();
    chk("R9 retry", gate_en, 1'b1);
    settle();
  endtask

  task automatic t_lock_report_ignore();
    lock_mode = 4'b1000;
    lock_raw = 1; tick(DGL + 2);
    chk("R10 report gate", gate_en, 1'b1);
    chk("R10 report flag", lock_flag, 1'b1);
    flt_clr = 1; tick(); flt_clr = 0;
    chk("R11 clear wins", lock_flag, 1'b0);
    tick();
    chk("R10 flag re-set", lock_flag, 1'b1);
    settle();
    foreach (ignore_modes[j]) begin
      lock_mode = ignore_modes[j];
      lock_raw = 1; tick(DGL + 3); lock_raw = 0;
      chk("R10 ignore gate", gate_en, 1'b1);
      chk("R10 ignore flag", lock_flag, 1'b0);
      settle();
    end
  endtask

  logic [3:0] ignore_modes [4] = '{4'b1001, 4'b1010, 4'b1100, 4'b1111};

  initial begin
    tick(3); rst_n = 1; tick();
    t_reset();
    t_deglitch();
    t_blank();
    t_next();
    t_thresh();
    t_ncyc();
    t_report_cbc();
    t_ignore_cbc(4'b0111);
    t_ignore_cbc(4'b1010);
    t_latch();
    t_retry();
    t_lock_report_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule